// File: doc/BRIEF.md
# Write-only I2C group register slave

This block sits on a two-wire serial control bus and holds the control settings of a small switch device. A bus master addresses it with a fixed seven-bit device address and the write direction bit. It then sends one byte that selects a control group, followed by one or more control bytes. Each control byte lands in the selected group, and the group pointer then steps to the next group. One transfer can therefore refresh any run of consecutive groups. The block never sends data. A read request is refused, and so is any byte that points past the last group.

Both bus lines pass through a two-flop synchronizer and a glitch filter running on the system clock. START and STOP are recognized only as an SDA edge while SCL is held high. The block acknowledges by pulling SDA low through an open-drain enable output during the ninth clock of a byte. Each group register drives a parallel output. A one-cycle update strobe marks every write to a group.

Top module: `i2cw_ctrl_slave`

## Requirements
- R1: After reset, group 0 holds 0x00, group 1 holds 0x40, group 2 holds 0x80, all strobes are low and SDA is released.
- R2: A first byte of 0x94 after START (device address 1001010, direction bit 0) is acknowledged: SDA is pulled low for the whole ninth clock and released after its falling edge.
- R3: A first byte carrying another address, or the address with direction bit 1, is not acknowledged. Every later byte is also ignored and not acknowledged until the next START or STOP.
- R4: The byte after an accepted address selects the group. Values 0 to 2 are acknowledged. A value of 3 or more is not acknowledged, and the following bytes are ignored.
- R5: A control byte is written to the selected group and raises that group's strobe for exactly one clock. No other group changes or strobes, and a group output changes only together with its strobe.
- R6: After each accepted control byte the group pointer advances by one, so consecutive control bytes fill consecutive groups.
- R7: A control byte that arrives after group 2 has been written in the same transfer is not acknowledged and changes nothing.
- R8: A STOP after any complete control byte ends the transfer. The groups written before it keep their new values.
- R9: A byte cut short by STOP or START changes no group.
- R10: A repeated START restarts address matching, even after a refused address.
- R11: A pulse on SCL shorter than the filter length (3 system clocks) is neither counted as a bit nor taken as a condition.
- R12: When SDA changes in the same instant as SCL rises, the bit takes the new SDA level and no START or STOP is recognized.
- R13: SDA is pulled only during the acknowledge clock of an accepted byte. It is asserted and released only while SCL is low, or else by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Drives SDA low when 1 (open-drain enable) |
| grp_q | output | 8*N_GROUPS | Group registers, group g at bits [8g+7:8g] |
| upd_stb | output | N_GROUPS | One-cycle pulse per group on each write |

## Verification
Bit sampling and START/STOP recognition both act on filtered line edges. When SDA changes at the moment SCL rises, both can be triggered in the same system clock. The bench provokes this by moving both lines on one clock edge for every bit of a control byte. The transfer is accepted only if the byte lands in its group with the new SDA levels, the transfer is not restarted or ended, and all acknowledges stay as expected.

// File: rtl/i2cw_pkg.sv
// Package: shared constants and types of the write-only group register slave.
// Assumes byte-wide transfers and a fixed set of bus phases.
package i2cw_pkg;

    localparam int BYTE_W = 8;

    // Position within a transfer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_GROUP,
        PH_DATA,
        PH_IGNORE
    } phase_t;

    // Events decoded from the filtered bus lines, each valid for one clock.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

endpackage

// File: rtl/i2cw_line_filter.sv
// Module: i2cw_line_filter
// Brings one bus line into the clock domain through two flops. The output
// changes only after the synchronized level has differed from it for
// FILT_LEN clocks in a row. Assumes the line idles high.
module i2cw_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             filt_q;

    // Synchronize the line, then accept a new level once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign line_o = filt_q;

endmodule

// File: rtl/i2cw_bus_events.sv
// Module: i2cw_bus_events
// Turns the filtered SCL/SDA levels into one-clock events. START and STOP
// need SCL high in both this and the previous clock. Assumes filtered inputs.
module i2cw_bus_events
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl;
            sda_prev_q <= sda;
        end
    end

    // Decode the edges and the bus conditions.
    always_comb begin
        ev.start = scl && scl_prev_q && sda_prev_q && !sda;
        ev.stop  = scl && scl_prev_q && !sda_prev_q && sda;
        ev.rise  = scl && !scl_prev_q;
        ev.fall  = !scl && scl_prev_q;
    end

endmodule

// File: rtl/i2cw_byte_engine.sv
// Module: i2cw_byte_engine
// Shifts in bytes and decides the acknowledge at the falling edge of the
// eighth clock. Then it steps through the address, group and control
// phases. It issues one write per accepted control byte, and a refused byte
// parks the engine until the next START or STOP. Assumes decoded bus events.
module i2cw_byte_engine
    import i2cw_pkg::*;
#(
    parameter int          N_GROUPS = 3,
    parameter logic [6:0]  DEV_ADDR = 7'b1001010,
    parameter int          IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              sda,
    output logic              ack_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam logic [3:0] BIT_FULL = 4'(BYTE_W);

    phase_t             phase_q;
    logic [3:0]         bit_cnt_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic               in_ack_q;
    logic               ack_q;
    logic [IDX_W-1:0]   idx_q;

    logic   active;
    logic   byte_done;
    logic   shift_ok;
    logic   accept;
    phase_t next_phase;

    // Qualify the moment a full byte is complete and whether bits may be taken.
    always_comb begin
        active    = (phase_q == PH_ADDR) || (phase_q == PH_GROUP) || (phase_q == PH_DATA);
        byte_done = active && ev.fall && !in_ack_q && (bit_cnt_q == BIT_FULL);
        shift_ok  = active && ev.rise && !in_ack_q && (bit_cnt_q < BIT_FULL);
    end

    // Judge the completed byte against the current phase.
    always_comb begin
        accept     = 1'b0;
        next_phase = PH_IGNORE;
        case (phase_q)
            PH_ADDR: begin
                accept     = (shreg_q == {DEV_ADDR, 1'b0});
                next_phase = PH_GROUP;
            end
            PH_GROUP: begin
                accept     = (shreg_q < BYTE_W'(N_GROUPS));
                next_phase = PH_DATA;
            end
            PH_DATA: begin
                accept     = (idx_q < IDX_W'(N_GROUPS));
                next_phase = PH_DATA;
            end
            default: begin
                accept     = 1'b0;
                next_phase = PH_IGNORE;
            end
        endcase
        if (!accept) begin
            next_phase = PH_IGNORE;
        end
    end

    // Advance the bit, byte and phase state on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            in_ack_q  <= 1'b0;
            ack_q     <= 1'b0;
            idx_q     <= '0;
        end else if (ev.start) begin
            phase_q   <= PH_ADDR;
            bit_cnt_q <= '0;
            in_ack_q  <= 1'b0;
            ack_q     <= 1'b0;
        end else if (ev.stop) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
            in_ack_q  <= 1'b0;
            ack_q     <= 1'b0;
        end else if (ev.fall && in_ack_q) begin
            in_ack_q  <= 1'b0;
            ack_q     <= 1'b0;
            bit_cnt_q <= '0;
        end else if (byte_done) begin
            in_ack_q <= 1'b1;
            ack_q    <= accept;
            phase_q  <= next_phase;
            if (phase_q == PH_GROUP && accept) begin
                idx_q <= shreg_q[IDX_W-1:0];
            end else if (phase_q == PH_DATA && accept) begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (shift_ok) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    assign ack_o     = ack_q;
    assign wr_en_o   = byte_done && (phase_q == PH_DATA) && accept;
    assign wr_idx_o  = idx_q;
    assign wr_data_o = shreg_q;

endmodule

// File: rtl/i2cw_group_regs.sv
// Module: i2cw_group_regs
// Holds one byte register per control group with its reset default, plus
// the per-group update strobe. Assumes at most one write per clock.
module i2cw_group_regs
    import i2cw_pkg::*;
#(
    parameter int                          N_GROUPS = 3,
    parameter int                          IDX_W    = 2,
    parameter logic [BYTE_W*N_GROUPS-1:0]  GRP_INIT = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [BYTE_W*N_GROUPS-1:0] grp_q,
    output logic [N_GROUPS-1:0]        upd_stb
);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        // Load the default on reset, otherwise take a write addressed to this group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q[g*BYTE_W +: BYTE_W] <= GRP_INIT[g*BYTE_W +: BYTE_W];
                upd_stb[g]                <= 1'b0;
            end else begin
                upd_stb[g] <= hit;
                if (hit) begin
                    grp_q[g*BYTE_W +: BYTE_W] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/i2cw_ctrl_slave.sv
// Module: i2cw_ctrl_slave
// Top level of the write-only group register slave. It filters both bus
// lines, decodes bus events, runs the byte engine and holds the group
// registers. SDA is only ever pulled low, never driven high.
// Assumes an external pull-up on both lines.
module i2cw_ctrl_slave
    import i2cw_pkg::*;
#(
    parameter int                          N_GROUPS = 3,
    parameter logic [6:0]                  DEV_ADDR = 7'b1001010,
    parameter int                          FILT_LEN = 3,
    parameter logic [BYTE_W*N_GROUPS-1:0]  GRP_INIT = {8'h80, 8'h40, 8'h00}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_pull_o,
    output logic [BYTE_W*N_GROUPS-1:0] grp_q,
    output logic [N_GROUPS-1:0]        upd_stb
);

    localparam int IDX_W = $clog2(N_GROUPS + 1);

    logic [1:0]        raw_lines;
    logic [1:0]        flt_lines;
    logic              scl_flt;
    logic              sda_flt;
    bus_ev_t           bus_ev;
    logic              start_ev;
    logic              stop_ev;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    assign raw_lines = {sda_i, scl_i};

    for (genvar k = 0; k < 2; k++) begin : g_line
        i2cw_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[k]),
            .line_o (flt_lines[k])
        );
    end

    assign scl_flt = flt_lines[0];
    assign sda_flt = flt_lines[1];

    i2cw_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (scl_flt),
        .sda   (sda_flt),
        .ev    (bus_ev)
    );

    assign start_ev = bus_ev.start;
    assign stop_ev  = bus_ev.stop;

    i2cw_byte_engine #(
        .N_GROUPS (N_GROUPS),
        .DEV_ADDR (DEV_ADDR),
        .IDX_W    (IDX_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (bus_ev),
        .sda       (sda_flt),
        .ack_o     (sda_pull_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    i2cw_group_regs #(
        .N_GROUPS (N_GROUPS),
        .IDX_W    (IDX_W),
        .GRP_INIT (GRP_INIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .grp_q   (grp_q),
        .upd_stb (upd_stb)
    );

endmodule

// File: rtl/i2cw_ctrl_slave_chk.sv
// Module: i2cw_ctrl_slave_chk
// Property checker bound into the top. It watches the strobes, the group
// outputs, the pull enable and the filtered SCL and condition events.
module i2cw_ctrl_slave_chk #(
    parameter int N_GROUPS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_pull_o,
    input logic [8*N_GROUPS-1:0] grp_q,
    input logic [N_GROUPS-1:0]   upd_stb,
    input logic                  scl_f,
    input logic                  start_ev,
    input logic                  stop_ev
);

    AST_ONE_GROUP_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_stb)) else $error("strobe on more than one group"); // R5

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !upd_stb[g] |-> $stable(grp_q[g*8 +: 8])) else $error("group changed without strobe"); // R5
        AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) upd_stb[g] |=> !upd_stb[g]) else $error("strobe longer than one clock"); // R5
    end

    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull_o) |-> !scl_f) else $error("pull asserted with SCL high"); // R13
    AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_pull_o) |-> (!scl_f || $past(start_ev) || $past(stop_ev))) else $error("pull released with SCL high"); // R13
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> !sda_pull_o) else $error("pull held after STOP"); // R3
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_ev |=> !sda_pull_o) else $error("pull held after START"); // R10

endmodule

bind i2cw_ctrl_slave i2cw_ctrl_slave_chk #(.N_GROUPS(N_GROUPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .grp_q      (grp_q),
    .upd_stb    (upd_stb),
    .scl_f      (scl_flt),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev)
);

// File: tb/i2cw_ctrl_slave_test.sv
// Bench: drives bus transfers as a master over a wired-AND SDA. A behavioural
// model tracks the expected registers, acknowledges and strobe counts. Outputs
// are compared on every clock once the lines have been quiet long enough.
module i2cw_ctrl_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_pull_o;
    logic [23:0] grp_q;
    logic [2:0]  upd_stb;

    int          n_chk = 0;
    int          n_fail = 0;
    int          quiet = 30;
    string       cur_req = "R1";
    logic [7:0]  exp_reg [3];
    logic        exp_pull = 1'b0;
    int          exp_cnt [3];
    int          got_cnt [3];
    int          m_phase = 0;
    int          m_idx = 0;
    logic        done = 1'b0;

    assign sda_bus = m_sda & ~sda_pull_o;

    always #5 clk = ~clk;

    i2cw_ctrl_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull_o),
        .grp_q      (grp_q),
        .upd_stb    (upd_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Count strobes, and compare outputs with the model on every quiet clock.
    always begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            for (int g = 0; g < 3; g++) begin
                if (upd_stb[g]) got_cnt[g]++;
            end
            if (quiet > 0) begin
                quiet--;
            end else begin
                for (int g = 0; g < 3; g++) chk(cur_req, grp_q[g*8 +: 8], exp_reg[g]);
                chk("R13", sda_pull_o, exp_pull);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_set(input logic v);
        @(negedge clk);
        m_scl = v;
        quiet = 12;
    endtask

    task automatic sda_set(input logic v);
        @(negedge clk);
        m_sda = v;
        quiet = 12;
    endtask

    // Expected reaction to a complete byte, from the requirements.
    task automatic model_eval(input logic [7:0] b, output logic ack);
        ack = 1'b0;
        case (m_phase)
            1: begin
                if (b == 8'h94) begin ack = 1'b1; m_phase = 2; end
                else m_phase = 4;
            end
            2: begin
                if (b < 8'd3) begin ack = 1'b1; m_idx = int'(b); m_phase = 3; end
                else m_phase = 4;
            end
            3: begin
                if (m_idx < 3) begin
                    ack = 1'b1;
                    exp_reg[m_idx] = b;
                    exp_cnt[m_idx]++;
                    m_idx++;
                end else m_phase = 4;
            end
            default: ack = 1'b0;
        endcase
    endtask

    task automatic start_cond();
        wait_clk(10);
        sda_set(1'b1);
        wait_clk(15);
        scl_set(1'b1);
        wait_clk(20);
        sda_set(1'b0);
        wait_clk(20);
        scl_set(1'b0);
        m_phase = 1;
    endtask

    task automatic stop_cond();
        wait_clk(10);
        sda_set(1'b0);
        wait_clk(15);
        scl_set(1'b1);
        wait_clk(20);
        sda_set(1'b1);
        wait_clk(30);
        m_phase = 0;
    endtask

    // One data bit; mode 1 adds a 2-clock SCL glitch, mode 2 moves SDA with the SCL rise.
    task automatic send_bit(input logic v, input int mode, input logic glitch);
        if (mode == 2) begin
            wait_clk(25);
            @(negedge clk);
            m_sda = v;
            m_scl = 1'b1;
            quiet = 12;
        end else begin
            wait_clk(10);
            sda_set(v);
            if (glitch) begin
                wait_clk(3);
                scl_set(1'b1);
                wait_clk(1);
                scl_set(1'b0);
                wait_clk(10);
            end
            wait_clk(15);
            scl_set(1'b1);
        end
        wait_clk(30);
        scl_set(1'b0);
    endtask

    task automatic send_byte(input logic [7:0] b, input int mode, input string req);
        logic ack;
        for (int i = 7; i >= 0; i--) send_bit(b[i], mode, (mode == 1) && (i == 4));
        model_eval(b, ack);
        exp_pull = ack;
        wait_clk(10);
        sda_set(1'b1);
        wait_clk(15);
        scl_set(1'b1);
        wait_clk(15);
        chk(req, sda_pull_o, ack);
        wait_clk(15);
        scl_set(1'b0);
        exp_pull = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) send_bit(b[i], 0, 1'b0);
    endtask

    task automatic chk_counts(input string req);
        wait_clk(20);
        for (int g = 0; g < 3; g++) chk(req, got_cnt[g], exp_cnt[g]);
    endtask

    initial begin
        exp_reg[0] = 8'h00;
        exp_reg[1] = 8'h40;
        exp_reg[2] = 8'h80;
        for (int g = 0; g < 3; g++) begin
            exp_cnt[g] = 0;
            got_cnt[g] = 0;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(20);
        // R1: reset defaults and released SDA
        chk("R1", grp_q[7:0], 8'h00);
        chk("R1", grp_q[15:8], 8'h40);
        chk("R1", grp_q[23:16], 8'h80);
        chk("R1", sda_pull_o, 0);
        chk("R1", upd_stb, 0);

        // R2 R4 R6: address, group 0, three control bytes
        cur_req = "R6";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h00, 0, "R4");
        send_byte(8'h11, 0, "R6");
        send_byte(8'h22, 0, "R6");
        send_byte(8'h33, 0, "R6");
        stop_cond();
        chk_counts("R5");

        // R8: single group then STOP
        cur_req = "R8";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h01, 0, "R4");
        send_byte(8'h5A, 0, "R8");
        stop_cond();
        chk_counts("R8");

        // R3: wrong address, then a read request
        cur_req = "R3";
        start_cond();
        send_byte(8'h96, 0, "R3");
        send_byte(8'h00, 0, "R3");
        send_byte(8'h77, 0, "R3");
        stop_cond();
        start_cond();
        send_byte(8'h95, 0, "R3");
        send_byte(8'h00, 0, "R3");
        send_byte(8'h66, 0, "R3");
        stop_cond();
        chk_counts("R3");

        // R4: group selectors out of range
        cur_req = "R4";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h03, 0, "R4");
        send_byte(8'h44, 0, "R4");
        stop_cond();
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'hFF, 0, "R4");
        send_byte(8'h45, 0, "R4");
        stop_cond();
        chk_counts("R4");

        // R7: bytes past the last group
        cur_req = "R7";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h02, 0, "R4");
        send_byte(8'hC3, 0, "R7");
        send_byte(8'h99, 0, "R7");
        send_byte(8'h98, 0, "R7");
        stop_cond();
        chk_counts("R7");

        // R9: byte cut short by STOP
        cur_req = "R9";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h00, 0, "R4");
        send_bits(8'h0F, 5);
        stop_cond();
        chk_counts("R9");

        // R10 and R9: partial byte cut by repeated START, then a new transfer
        cur_req = "R10";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h00, 0, "R4");
        send_bits(8'h5F, 3);
        start_cond();
        send_byte(8'h94, 0, "R10");
        send_byte(8'h02, 0, "R10");
        send_byte(8'hE7, 0, "R10");
        stop_cond();
        chk_counts("R10");

        // R10: repeated START after a refused address
        start_cond();
        send_byte(8'h90, 0, "R3");
        start_cond();
        send_byte(8'h94, 0, "R10");
        send_byte(8'h01, 0, "R10");
        send_byte(8'h3C, 0, "R10");
        stop_cond();
        chk_counts("R10");

        // R11: short SCL pulse inside a control byte
        cur_req = "R11";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h00, 0, "R4");
        send_byte(8'hB6, 1, "R11");
        stop_cond();
        chk_counts("R11");
        chk("R11", grp_q[7:0], 8'hB6);

        // R12: SDA moves in the same instant SCL rises
        cur_req = "R12";
        start_cond();
        send_byte(8'h94, 0, "R2");
        send_byte(8'h01, 0, "R4");
        send_byte(8'h4D, 2, "R12");
        send_byte(8'hA2, 2, "R12");
        stop_cond();
        chk_counts("R12");
        chk("R12", grp_q[15:8], 8'h4D);
        chk("R12", grp_q[23:16], 8'hA2);

        wait_clk(20);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule